// File: doc/BRIEF.md
# Three-Lane 7:1 Parallel Serializer

This block turns a 21-bit parallel word into three serial data lanes and one forwarded clock lane. A new word is presented on every rising edge of a slow word clock. Each lane sends seven bits per word period, one bit per cycle of a bit clock that runs at seven times the word rate. The phase of the bit clock relative to the word clock is known. A fourth lane carries a fixed seven-slot pattern, so a receiver sees a clock at the word rate that lines up with the data slots.

All logic runs in the bit-clock domain. The word clock is sampled there, and its rising edge captures the input word. A slot counter produces a load strobe once every seven bit cycles. On that strobe the captured word moves into per-lane shift registers, so consecutive words follow each other with no idle slot. An active-low power-down input turns every output off and drops the output-enable flag, which stands in for electrical high impedance. After power-down ends, the outputs stay off until a complete word has been captured with power-down released.

Top module: `tri_lane_serializer`

## Requirements
- R1: A word is captured from `din` at the first `clk_bit` rising edge at which `word_clk` is high after having been low (the capture edge).
- R2: Lane k (`ser_data[k]`, k = 0..2) carries `din[7k+j]` in slot j, so the least significant bit of the lane goes first. Slot j of a word is driven during the bit cycle that follows the (6+j)-th `clk_bit` rising edge after its capture edge.
- R3: When word clock edges come every seven bit cycles, the slots of successive words follow back to back with no gap and no repeated slot.
- R4: While enabled, `ser_clk` shows the values 1,1,0,0,0,1,1 in slots 0 to 6 of every word. Its rising edge therefore comes two bit-times before each word's slot 0.
- R5: While `pwr_n` is low, from the next `clk_bit` edge on, `out_en` is 0 and `ser_data` and `ser_clk` are all 0.
- R6: After reset or after `pwr_n` goes high again, `out_en` stays 0 until the load of the first word whose capture edge came while `pwr_n` was high. `out_en` then rises at the start of that word's slot 0.
- R7: After reset, and at any time `out_en` is 0, all serial outputs are 0.
- R8: Once `out_en` is 1, it stays 1 for as long as `pwr_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock, seven times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Slow word clock; its rising edge marks a new word |
| pwr_n | input | 1 | Active-low power-down |
| din | input | 21 | Parallel input word |
| ser_data | output | 3 | Serial data lanes, one bit per bit cycle |
| ser_clk | output | 1 | Forwarded clock lane |
| out_en | output | 1 | Output enable; 0 stands for high impedance |

## Verification
A slot counter that is out of phase shows up within one word period. The load lands on the wrong cycle, which moves every lane's bits by one or more slots, so a word read back from the lanes no longer matches the input. The forwarded clock pattern also stops lining up with slot 0. A wrong enable or armed state shows at `out_en` during the first word period after power-down is released: either a partial word leaks out, or a complete word is held back. A lane routing error corrupts the first enabled word that has distinct bits in each lane.

// File: rtl/tri_lane_serializer.sv
`timescale 1ns/1ps
module tri_lane_serializer #(
  parameter int LANES = 3,
  parameter int SLOTS = 7,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                   clk_bit,
  input  logic                   rst_n,
  input  logic                   word_clk,
  input  logic                   pwr_n,
  input  logic [LANES*SLOTS-1:0] din,
  output logic [LANES-1:0]       ser_data,
  output logic                   ser_clk,
  output logic                   out_en
);
  localparam int WIDTH = LANES * SLOTS;
  localparam int CW    = $clog2(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic             wclk_q;
  logic [WIDTH-1:0] cap_q;
  logic [CW-1:0]    slot_q;
  logic [SLOTS-1:0] ck_q;
  logic             armed_q;
  logic             oe_q;

  wire rise = word_clk & ~wclk_q;
  wire load = (slot_q == LAST);

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q  <= 1'b0;
      cap_q   <= '0;
      slot_q  <= '0;
      ck_q    <= '0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      wclk_q <= word_clk;
      if (rise) cap_q <= din;
      if (rise)      slot_q <= CW'(1);
      else if (load) slot_q <= '0;
      else           slot_q <= slot_q + 1'b1;
      ck_q    <= load ? CLK_PATTERN : {1'b0, ck_q[SLOTS-1:1]};
      armed_q <= pwr_n & (armed_q | rise);
      if (!pwr_n)               oe_q <= 1'b0;
      else if (load && armed_q) oe_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLOTS-1:0] sh_q;
    always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= cap_q[k*SLOTS +: SLOTS];
      else           sh_q <= {1'b0, sh_q[SLOTS-1:1]};
    end
    assign ser_data[k] = oe_q & sh_q[0];
  end

  assign ser_clk = oe_q & ck_q[0];
  assign out_en  = oe_q;
endmodule

// File: rtl/tri_lane_serializer_chk.sv
`timescale 1ns/1ps
module tri_lane_serializer_chk #(
  parameter int LANES = 3,
  parameter int SLOTS = 7,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input logic             clk_bit,
  input logic             rst_n,
  input logic             pwr_n,
  input logic [LANES-1:0] ser_data,
  input logic             ser_clk,
  input logic             out_en
);
  localparam int CW = $clog2(SLOTS);
  logic [CW-1:0] ph_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)                        ph_q <= '0;
    else if (!out_en)                  ph_q <= '0;
    else if (ph_q == CW'(SLOTS - 1))   ph_q <= '0;
    else                               ph_q <= ph_q + 1'b1;
  end

  assert_pd_silences_R5: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pwr_n |=> (!out_en && ser_data == '0 && !ser_clk));

  assert_off_is_zero_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !out_en |-> (ser_data == '0 && !ser_clk));

  assert_enable_after_word_R6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(out_en) |-> $past(pwr_n));

  assert_enable_holds_R8: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (out_en && pwr_n) |=> out_en);

  assert_clock_pattern_R4: assert property (@(posedge clk_bit) disable iff (!rst_n)
    out_en |-> (ser_clk == CLK_PATTERN[ph_q]));
endmodule

bind tri_lane_serializer tri_lane_serializer_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .CLK_PATTERN(CLK_PATTERN)
) u_chk (
  .clk_bit(clk_bit), .rst_n(rst_n), .pwr_n(pwr_n),
  .ser_data(ser_data), .ser_clk(ser_clk), .out_en(out_en)
);

// File: tb/tri_lane_serializer_test.sv
`timescale 1ns/1ps
module tri_lane_serializer_test;
  logic        clk_bit = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_clk = 1'b0;
  logic        pwr_n = 1'b1;
  logic [20:0] din = '0;
  logic [2:0]  ser_data;
  logic        ser_clk;
  logic        out_en;

  int checks = 0;
  int failures = 0;

  localparam logic [6:0] PAT = 7'b1100011;

  // {stimulus word, expected word rebuilt from the three lanes}
  localparam logic [41:0] VEC [8] = '{
    {21'h1FFFFF, 21'h1FFFFF}, {21'h000001, 21'h000001},
    {21'h100000, 21'h100000}, {21'h0AAAAA, 21'h0AAAAA},
    {21'h155555, 21'h155555}, {21'h00007F, 21'h00007F},
    {21'h1FC000, 21'h1FC000}, {21'h003F80, 21'h003F80}
  };

  tri_lane_serializer uut (
    .clk_bit(clk_bit), .rst_n(rst_n), .word_clk(word_clk), .pwr_n(pwr_n),
    .din(din), .ser_data(ser_data), .ser_clk(ser_clk), .out_en(out_en)
  );

  always #4 clk_bit = ~clk_bit;

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One word period of seven bit cycles: sample the outputs of the previous
  // word at each negedge, then drive the next word (R1, R2, R3).
  task automatic word_period(input logic [20:0] nxt, input logic [20:0] prev,
                             input bit exp_on, input int rel_at, input string tag);
    logic [20:0] got = '0;
    logic [6:0]  gck = '0;
    bit          oe_ok = 1'b1;
    for (int j = 0; j < 7; j++) begin
      @(negedge clk_bit);
      for (int k = 0; k < 3; k++) got[7*k+j] = ser_data[k];
      gck[j] = ser_clk;
      if (out_en !== exp_on) oe_ok = 1'b0;
      if (j == 0) begin word_clk = 1'b1; din = nxt; end
      if (j == 4) word_clk = 1'b0;
      if (j == rel_at) pwr_n = 1'b1;
    end
    check(oe_ok, {tag, " out_en R6 R8"}, 32'(out_en), 32'(exp_on));
    if (exp_on) begin
      check(got == prev, {tag, " lane data R2 R3"}, 32'(got), 32'(prev));
      check(gck == PAT, {tag, " clock lane R4"}, 32'(gck), 32'(PAT));
    end else begin
      check(got == '0 && gck == '0, {tag, " silent R7"}, 32'({gck, got}), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_bit);
    rst_n = 1'b1;
    @(negedge clk_bit);
    check(out_en == 1'b0 && ser_data == '0 && ser_clk == 1'b0, "reset state R7",
          32'({out_en, ser_clk, ser_data}), 32'd0);

    // table walk: first word after reset is not preceded by output (R6)
    for (int i = 0; i < 8; i++)
      word_period(VEC[i][41:21], (i == 0) ? 21'h0 : VEC[i-1][20:0], i > 0, -1, "table");
    word_period(21'h0, VEC[7][20:0], 1'b1, -1, "flush");

    // power-down entry (R5)
    @(negedge clk_bit);
    pwr_n = 1'b0;
    @(negedge clk_bit);
    check(out_en == 1'b0 && ser_data == '0 && ser_clk == 1'b0, "power-down immediate R5",
          32'({out_en, ser_clk, ser_data}), 32'd0);
    word_period(21'h0F0F0F, 21'h0, 1'b0, -1, "pd hold R5");
    // word captured while still powered down, release mid-period (R6)
    word_period(21'h12345, 21'h0, 1'b0, 2, "partial R6");
    // that partial word is loaded but must stay hidden (R6)
    word_period(21'h0ABCDE, 21'h0, 1'b0, -1, "hidden R6");
    word_period(21'h1C0E07, 21'h0ABCDE, 1'b1, -1, "first full R6");
    word_period(21'h0, 21'h1C0E07, 1'b1, -1, "after release R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule